// File: doc/BRIEF.md
# Dual-Window Watchdog Supervisor

This block supervises a processor through the periodic trigger pulses that the processor sends. It holds the processor in reset while the supply is not good and for a fixed settling time after the supply becomes good. After every reset the processor has to confirm the handshake by pulling the mode line low within a set time. From then on the processor must place each trigger edge inside a timed enable window that follows a disable window. A trigger that is early, missing or held too long causes a reset pulse.

Two window sets exist. The short set serves a running processor. The long set is entered by a high mode level, lets a sleeping processor be woken up at regular intervals, and has two selectable lengths. A level change on any wake line ends long operation with a reset. A safety enable output reports a healthy processor. It turns on only after a run of correct triggers in short operation. Every duration is a count of clock cycles. The trigger and mode inputs are synchronised inside the block. The wake lines arrive already clean.

Top module: `wwdt_supervisor`

## Requirements
- R1: While pwr_ok is low, rst_n_out is 0 and safe_en is 0. After pwr_ok rises, rst_n_out first reads 1 after exactly T_PWRUP rising clock edges.
- R2: rst_oe is 1 exactly when rst_n_out is 0. This models an open-drain pin that only ever pulls low.
- R3: After a reset is released, a mode_in level that stays high keeps the block waiting. rst_n_out then stays 1 for T_SWITCH cycles, falls, and the waiting phase starts again after the pulse. A low mode_in ends the waiting phase.
- R4: Every reset caused by a fault holds rst_n_out at 0 for exactly T_RSTPULSE cycles. Power-up resets are not included.
- R5: trig_in and mode_in act two edges after the edge that first samples their new level. A reference (mode drop or accepted trigger) acts at edge e. A trigger edge acting at e+d is accepted when T_SDIS < d <= T_SDIS+T_SEN. A trigger edge with d <= T_SDIS is early and resets at its acting edge.
- R6: If no trigger edge arrives, rst_n_out falls at edge e+T_SDIS+T_SEN.
- R7: A synchronised trigger that stays high for more than TRIG_MAX cycles resets at the cycle that goes past the limit. A pulse of exactly TRIG_MAX cycles is legal.
- R8: safe_en turns on at the third accepted short-mode trigger in a row. Any reset clears it, and three new accepted triggers are then needed.
- R9: A high mode level during short monitoring switches to long monitoring at its acting edge. safe_en is 0 there. Long monitoring ignores mode_in and ends only through a reset.
- R10: In long monitoring the disable and enable windows are T_LDIS_A and T_LEN_A when tsel is 0, and T_LDIS_B and T_LEN_B when tsel is 1. The acceptance and timeout rules of R5 and R6 apply with these lengths.
- R11: In long monitoring, a rise or a fall on any wake line makes rst_n_out 0 right after the first edge that samples the new level. In short monitoring wake lines have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; all windows count its cycles |
| pwr_ok | input | 1 | Supply-good flag, low clears all state asynchronously |
| trig_in | input | 1 | Processor trigger, asynchronous |
| mode_in | input | 1 | Handshake and window-set select, high means long monitoring |
| tsel | input | 1 | Chooses between the two long window lengths |
| wake | input | NWAKE | Clean wake-up lines |
| rst_n_out | output | 1 | Active-low processor reset |
| rst_oe | output | 1 | Drive enable of the open-drain reset pin |
| safe_en | output | 1 | Safety enable for peripheral components |

## Verification
The assertions assume that wake lines and tsel are synchronous to clk. They also assume that T_RSTPULSE and T_PWRUP are at least two cycles, so that a falling reset must still be low one cycle later. The stimulus changes every input one time unit after a rising edge. It keeps trigger pulses between one and three cycles long, except in the deliberate over-length cases. It spaces trigger raises at least six cycles apart, so each pulse ends before the next begins. tsel is changed only while the block is in short monitoring, never inside a long window.

// File: rtl/wwdt_supervisor.sv
module wwdt_supervisor #(
  parameter int NWAKE      = 6,
  parameter int T_PWRUP    = 20,
  parameter int T_SWITCH   = 25,
  parameter int T_RSTPULSE = 6,
  parameter int T_SDIS     = 10,
  parameter int T_SEN      = 10,
  parameter int T_LDIS_A   = 30,
  parameter int T_LEN_A    = 30,
  parameter int T_LDIS_B   = 60,
  parameter int T_LEN_B    = 60,
  parameter int TRIG_MAX   = 4,
  parameter int GOOD_N     = 3
) (
  input  logic             clk,
  input  logic             pwr_ok,
  input  logic             trig_in,
  input  logic             mode_in,
  input  logic             tsel,
  input  logic [NWAKE-1:0] wake,
  output logic             rst_n_out,
  output logic             rst_oe,
  output logic             safe_en
);
  localparam int TSUM = T_PWRUP + T_SWITCH + T_RSTPULSE + T_SDIS + T_SEN +
                        T_LDIS_A + T_LEN_A + T_LDIS_B + T_LEN_B;
  localparam int CW = $clog2(TSUM + 1);
  localparam int HW = $clog2(TRIG_MAX + 1);
  localparam int GW = $clog2(GOOD_N + 1);

  typedef enum logic [2:0] {
    ST_PWR, ST_RST, ST_SW, ST_SDIS, ST_SEN, ST_LDIS, ST_LEN
  } st_t;

  st_t st, st_n;
  logic [CW-1:0] cnt, l_dis_m1, l_en_m1;
  logic [HW-1:0] hcnt;
  logic [GW-1:0] good;
  logic [1:0] trig_sy, mode_sy;
  logic trig_q;
  logic [NWAKE-1:0] wake_q;
  logic clr, flt, ginc;
  logic trig_s, mode_s, trig_rise, too_long, wake_edge;
  logic in_short, in_long, in_dis, sw_expire;

  assign trig_s    = trig_sy[1];
  assign mode_s    = mode_sy[1];
  assign trig_rise = trig_s & ~trig_q;
  assign too_long  = trig_s & (hcnt == HW'(TRIG_MAX));
  assign wake_edge = |(wake ^ wake_q);
  assign in_short  = (st == ST_SDIS) || (st == ST_SEN);
  assign in_long   = (st == ST_LDIS) || (st == ST_LEN);
  assign in_dis    = (st == ST_SDIS) || (st == ST_LDIS);
  assign sw_expire = (st == ST_SW) && mode_s && (cnt == CW'(T_SWITCH - 1));
  assign l_dis_m1  = tsel ? CW'(T_LDIS_B - 1) : CW'(T_LDIS_A - 1);
  assign l_en_m1   = tsel ? CW'(T_LEN_B - 1)  : CW'(T_LEN_A - 1);

  assign rst_n_out = !((st == ST_PWR) || (st == ST_RST));
  assign rst_oe    = ~rst_n_out;
  assign safe_en   = in_short && (good == GW'(GOOD_N));

  always_comb begin
    st_n = st;
    clr  = 1'b0;
    flt  = 1'b0;
    ginc = 1'b0;
    case (st)
      ST_PWR:
        if (cnt == CW'(T_PWRUP - 1)) begin st_n = ST_SW; clr = 1'b1; end
      ST_RST:
        if (cnt == CW'(T_RSTPULSE - 1)) begin st_n = ST_SW; clr = 1'b1; end
      ST_SW:
        if (!mode_s) begin st_n = ST_SDIS; clr = 1'b1; end
        else if (sw_expire) flt = 1'b1;
      ST_SDIS:
        if (too_long || trig_rise) flt = 1'b1;
        else if (mode_s) begin st_n = ST_LDIS; clr = 1'b1; end
        else if (cnt == CW'(T_SDIS - 1)) begin st_n = ST_SEN; clr = 1'b1; end
      ST_SEN:
        if (too_long) flt = 1'b1;
        else if (trig_rise) begin st_n = ST_SDIS; clr = 1'b1; ginc = 1'b1; end
        else if (mode_s) begin st_n = ST_LDIS; clr = 1'b1; end
        else if (cnt == CW'(T_SEN - 1)) flt = 1'b1;
      ST_LDIS:
        if (too_long || trig_rise || wake_edge) flt = 1'b1;
        else if (cnt == l_dis_m1) begin st_n = ST_LEN; clr = 1'b1; end
      ST_LEN:
        if (too_long || wake_edge) flt = 1'b1;
        else if (trig_rise) begin st_n = ST_LDIS; clr = 1'b1; end
        else if (cnt == l_en_m1) flt = 1'b1;
      default: flt = 1'b1;
    endcase
    if (flt) begin
      st_n = ST_RST;
      clr  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) begin
      st      <= ST_PWR;
      cnt     <= '0;
      hcnt    <= '0;
      good    <= '0;
      trig_sy <= '0;
      mode_sy <= 2'b11;
      trig_q  <= 1'b0;
      wake_q  <= '0;
    end else begin
      st      <= st_n;
      cnt     <= clr ? '0 : cnt + CW'(1);
      trig_sy <= {trig_sy[0], trig_in};
      mode_sy <= {mode_sy[0], mode_in};
      trig_q  <= trig_s;
      wake_q  <= wake;
      if (!trig_s) hcnt <= '0;
      else if (hcnt != HW'(TRIG_MAX)) hcnt <= hcnt + HW'(1);
      if (flt || (st_n == ST_LDIS && !in_long)) good <= '0;
      else if (ginc && good != GW'(GOOD_N)) good <= good + GW'(1);
    end
  end
endmodule

module wwdt_supervisor_chk (
  input logic clk,
  input logic pwr_ok,
  input logic rst_n_out,
  input logic safe_en,
  input logic trig_rise,
  input logic in_long,
  input logic in_dis,
  input logic wake_edge,
  input logic sw_expire
);
  // R1
  always @(posedge clk)
    if (!pwr_ok) pwr_hold_chk: assert (!rst_n_out && !safe_en);

  // R3
  sw_timeout_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
    sw_expire |=> !rst_n_out);

  // R4
  pulse_min_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
    $fell(rst_n_out) |=> !rst_n_out);

  // R5
  early_trig_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
    (in_dis && trig_rise) |=> !rst_n_out);

  // R8
  en_cause_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
    $rose(safe_en) |-> $past(trig_rise));

  // R8
  en_after_rst_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
    $rose(rst_n_out) |-> !safe_en);

  // R11
  wake_abort_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
    (in_long && wake_edge) |=> !rst_n_out);
endmodule

bind wwdt_supervisor wwdt_supervisor_chk u_chk (
  .clk(clk), .pwr_ok(pwr_ok), .rst_n_out(rst_n_out), .safe_en(safe_en),
  .trig_rise(trig_rise), .in_long(in_long), .in_dis(in_dis),
  .wake_edge(wake_edge), .sw_expire(sw_expire)
);

// File: tb/sim_wwdt_supervisor.sv
module sim_wwdt_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int T0 = 20, T1 = 25, T6 = 6, T2 = 10, T3 = 10;
  localparam int T4A = 30, T5A = 30, T4B = 60, T5B = 60, TM = 4;

  logic clk = 1'b0, pwr_ok = 1'b1, trig = 1'b0, mode = 1'b1, tsel = 1'b0;
  logic [5:0] wake = '0;
  logic rst_n, oe, en;

  wwdt_supervisor #(
    .NWAKE(6), .T_PWRUP(T0), .T_SWITCH(T1), .T_RSTPULSE(T6), .T_SDIS(T2), .T_SEN(T3),
    .T_LDIS_A(T4A), .T_LEN_A(T5A), .T_LDIS_B(T4B), .T_LEN_B(T5B), .TRIG_MAX(TM), .GOOD_N(3)
  ) u0 (
    .clk(clk), .pwr_ok(pwr_ok), .trig_in(trig), .mode_in(mode), .tsel(tsel), .wake(wake),
    .rst_n_out(rst_n), .rst_oe(oe), .safe_en(en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, refc = 0, goodm = 0;
  bit lng = 1'b0;

  task automatic tick();
    @(posedge clk); #1; cyc++;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit accept(input int g);
    int lo, hi;
    lo = lng ? (tsel ? T4B : T4A) : T2;
    hi = lo + (lng ? (tsel ? T5B : T5A) : T3);
    return (g > lo) && (g <= hi);
  endfunction

  task automatic pulse_len(output int n);
    n = 0;
    while (!rst_n && n < 1000) begin tick(); n++; end
  endtask

  task automatic resync(input string tag);
    int n;
    pulse_len(n);
    chk({"R4 pulse after ", tag}, n, T6);
    if (mode) begin tick(); tick(); mode = 1'b0; refc = cyc; end
    else refc = cyc - 2;
    goodm = 0;
    lng = 1'b0;
  endtask

  task automatic fire(input int g, input int w, input string tag);
    int c;
    bit ok;
    while (cyc < refc + g) tick();
    c = cyc;
    trig = 1'b1;
    for (int i = 1; i <= 3; i++) begin tick(); if (i == w) trig = 1'b0; end
    ok = accept(g);
    chk({tag, " reset after trigger"}, rst_n, ok);
    chk("R2 open-drain enable", oe, !ok);
    if (ok) begin
      refc = c;
      if (!lng && goodm < 3) goodm++;
      chk("R8 enable level", en, (goodm == 3 && !lng));
    end else begin
      resync(tag);
      chk("R8 enable cleared by reset", en, 0);
    end
  endtask

  task automatic hold_trig(input int g, input int w);
    int c;
    while (cyc < refc + g) tick();
    c = cyc;
    trig = 1'b1;
    while (cyc < c + TM + 2) begin tick(); if (cyc == c + w) trig = 1'b0; end
    chk("R7 before limit", rst_n, 1);
    tick();
    chk("R7 long pulse", rst_n, (w > TM) ? 0 : 1);
    if (w > TM) resync("R7");
    else begin refc = c; if (goodm < 3) goodm++; end
  endtask

  task automatic go_long();
    tick();
    mode = 1'b1;
    refc = cyc;
    lng = 1'b1;
    tick(); tick(); tick();
    chk("R9 enable off in long mode", en, 0);
    chk("R9 no reset on mode switch", rst_n, 1);
    goodm = 0;
  endtask

  initial begin
    int n, e;
    void'($urandom(32'd77));
    #1 pwr_ok = 1'b0;
    tick(); tick(); tick();
    chk("R1 reset while supply bad", rst_n, 0);
    chk("R1 enable while supply bad", en, 0);
    chk("R2 pin driven during reset", oe, 1);
    pwr_ok = 1'b1;
    n = 0;
    do begin tick(); n++; end while (!rst_n && n < 1000);
    chk("R1 power-up length", n, T0);

    for (int k = 0; k < 2; k++) begin
      e = cyc;
      while (cyc < e + T1 - 1) tick();
      chk("R3 waiting phase high", rst_n, 1);
      tick();
      chk("R3 switch timeout", rst_n, 0);
      pulse_len(n);
      chk("R4 switch timeout pulse", n, T6);
    end
    tick(); tick();
    mode = 1'b0;
    refc = cyc;

    fire(T2 + 1, 1, "R5");
    fire(T2 + T3, 2, "R5");
    fire(15, 3, "R5");
    chk("R8 enable after three", en, 1);

    wake[2] = 1'b1;
    tick(); tick();
    chk("R11 wake ignored in short mode", rst_n, 1);

    fire(T2, 1, "R5");
    fire(12, 1, "R5");
    fire(12, 1, "R5");
    chk("R8 two after reset", en, 0);
    fire(12, 1, "R5");

    while (cyc < refc + 2 + T2 + T3) tick();
    chk("R6 last cycle of window", rst_n, 1);
    tick();
    chk("R6 missed trigger", rst_n, 0);
    resync("R6");

    hold_trig(12, TM);
    hold_trig(12, TM + 1);

    for (int k = 0; k < 40; k++) begin
      int g, w;
      g = 6 + int'($urandom % 15);
      w = 1 + int'($urandom % 3);
      fire(g, w, "R5");
    end

    fire(12, 1, "R5"); fire(12, 1, "R5"); fire(12, 1, "R5");
    chk("R8 enable before long", en, 1);
    go_long();
    fire(T4A + 1, 2, "R10");
    fire(T4A + T5A, 1, "R10");

    go_long();
    tick();
    mode = 1'b0;
    fire(12, 1, "R9");

    tsel = 1'b1;
    go_long();
    fire(35, 1, "R10");
    go_long();
    fire(70, 2, "R10");
    fire(T4B + T5B, 1, "R10");
    while (cyc < refc + 2 + T4B + T5B) tick();
    chk("R10 long B window end", rst_n, 1);
    tick();
    chk("R10 long B timeout", rst_n, 0);
    resync("R10");
    tsel = 1'b0;

    go_long();
    tick(); tick();
    wake[4] = 1'b1;
    tick();
    chk("R11 rising wake", rst_n, 0);
    resync("R11");
    go_long();
    tick();
    wake[2] = 1'b0;
    tick();
    chk("R11 falling wake", rst_n, 0);
    resync("R11");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog R1 actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule